// File: doc/BRIEF.md
# External Clock Bypass Handshake Controller

This block sequences the move of the system clocks onto an external source. Two parties can ask for a bypass. The lifecycle controller requests a bypass of the io clocks. Software requests a bypass of all clocks, and that request counts only while the debug-enable input is On. The block forwards each request to the clock sources as a registered output. The sources answer with acknowledgements that arrive asynchronously. Each acknowledgement passes through a two-flop synchronizer before the block decodes it.

The lifecycle controller gets its acknowledgement back only when two conditions hold: the io clock sources have acknowledged the bypass, and the divided clocks have acknowledged a step-down. The synchronized all-clock acknowledgement is copied unchanged to a status output that software can read.

Every control and handshake signal is a 4-bit multi-bit boolean. On is 4'hA and Off is 4'h5. Any of the other 14 codes is never taken as On. The divider step-down command follows only valid codes and ignores invalid ones.

Top module: `clkbyp_ctrl`

## Requirements
- R1: While `rst_i` is high, and on the first clock after it is released, `io_byp_req_o`, `all_byp_req_o`, `lc_byp_ack_o`, `div_step_o` and `ext_status_o` read Off (4'h5).
- R2: One clock after `lc_byp_req_i` is sampled, `io_byp_req_o` is On (4'hA) if that sample was exactly 4'hA, and Off (4'h5) for each of the other 15 codes.
- R3: One clock after sampling, `all_byp_req_o` is On only if `sw_byp_req_i` and `lc_dbg_en_i` were both exactly 4'hA; otherwise it is Off.
- R4: `ext_status_o` equals the raw 4-bit value of `all_byp_ack_i`, including invalid codes, three clocks after that input settles. Two clocks come from the synchronizer and one from the output register.
- R5: When `lc_byp_req_i` is On, `io_byp_ack_i` is On and `stepdn_ack_i` is On, `lc_byp_ack_o` becomes On three clocks after the last of these settles. It is still Off two clocks after that point.
- R6: An acknowledgement code other than 4'hA on `io_byp_ack_i` or `stepdn_ack_i` counts as not acknowledged, so `lc_byp_ack_o` stays Off.
- R7: One clock after sampling, `div_step_o` becomes On when `stepdn_req_i` is 4'hA and Off when it is 4'h5. Any other code leaves `div_step_o` unchanged.
- R8: When `lc_byp_req_i` leaves On, `io_byp_req_o` and `lc_byp_ack_o` both read Off one clock later, even if every acknowledgement is still On.
- R9: `io_byp_req_o`, `all_byp_req_o`, `lc_byp_ack_o` and `div_step_o` only ever carry 4'hA or 4'h5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lc_byp_req_i | input | 4 | Lifecycle io-clock bypass request (multi-bit boolean) |
| lc_dbg_en_i | input | 4 | Debug enable (multi-bit boolean); gates the software request |
| sw_byp_req_i | input | 4 | Software all-clock bypass request (multi-bit boolean) |
| io_byp_ack_i | input | 4 | Asynchronous io bypass acknowledgement |
| all_byp_ack_i | input | 4 | Asynchronous all-clock bypass acknowledgement |
| stepdn_req_i | input | 4 | Divider step-down command (multi-bit boolean) |
| stepdn_ack_i | input | 4 | Asynchronous step-down acknowledgement from the dividers |
| io_byp_req_o | output | 4 | Io bypass request to the clock sources |
| all_byp_req_o | output | 4 | All-clock bypass request to the clock sources |
| lc_byp_ack_o | output | 4 | Bypass acknowledgement back to the lifecycle controller |
| div_step_o | output | 4 | Step-down command to the dividers |
| ext_status_o | output | 4 | Status field holding the synchronized all-clock acknowledgement |

## Verification
The hardest case to reach is the lifecycle acknowledgement being held back by only one of its two conditions. To get there, the request and one acknowledgement must already be On and settled through the synchronizers. The other acknowledgement must then carry an invalid code. The stimulus first brings the io acknowledgement to On and holds it past the synchronizer latency. It then sweeps the step-down acknowledgement through all 16 codes, and repeats the sweep with the roles swapped. For each code it checks the output only after the full three-clock path has elapsed.

// File: rtl/clkbyp_pkg.sv
package clkbyp_pkg;
  localparam int MW = 4;
  typedef logic [MW-1:0] mubi_t;
  localparam mubi_t MUBI_ON  = 4'hA;
  localparam mubi_t MUBI_OFF = 4'h5;

  function automatic logic mubi_on(input mubi_t v);
    return v == MUBI_ON;
  endfunction

  function automatic logic mubi_off(input mubi_t v);
    return v == MUBI_OFF;
  endfunction
endpackage

// File: rtl/clkbyp_sync.sv
module clkbyp_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) stg[s] <= RST_VAL;
          else       stg[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) stg[s] <= RST_VAL;
          else       stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/clkbyp_div_ctl.sv
module clkbyp_div_ctl
  import clkbyp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  mubi_t req_i,
  output mubi_t step_o
);
  mubi_t step_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)              step_q <= MUBI_OFF;
    else if (mubi_on(req_i))  step_q <= MUBI_ON;
    else if (mubi_off(req_i)) step_q <= MUBI_OFF;
  end

  assign step_o = step_q;
endmodule

// File: rtl/clkbyp_lc_ack.sv
module clkbyp_lc_ack
  import clkbyp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  mubi_t lc_req_i,
  input  mubi_t io_ack_s_i,
  input  mubi_t step_ack_s_i,
  output mubi_t lc_ack_o
);
  mubi_t ack_q;
  logic  grant;

  always_comb grant = mubi_on(lc_req_i) && mubi_on(io_ack_s_i) && mubi_on(step_ack_s_i);

  always_ff @(posedge clk_i) begin
    if (rst_i)      ack_q <= MUBI_OFF;
    else if (grant) ack_q <= lc_req_i;
    else            ack_q <= MUBI_OFF;
  end

  assign lc_ack_o = ack_q;
endmodule

// File: rtl/clkbyp_ctrl.sv
module clkbyp_ctrl
  import clkbyp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [MW-1:0] lc_byp_req_i,
  input  logic [MW-1:0] lc_dbg_en_i,
  input  logic [MW-1:0] sw_byp_req_i,
  input  logic [MW-1:0] io_byp_ack_i,
  input  logic [MW-1:0] all_byp_ack_i,
  input  logic [MW-1:0] stepdn_req_i,
  input  logic [MW-1:0] stepdn_ack_i,
  output logic [MW-1:0] io_byp_req_o,
  output logic [MW-1:0] all_byp_req_o,
  output logic [MW-1:0] lc_byp_ack_o,
  output logic [MW-1:0] div_step_o,
  output logic [MW-1:0] ext_status_o
);
  localparam int NACK = 3;

  mubi_t ack_raw [NACK];
  mubi_t ack_syn [NACK];

  assign ack_raw[0] = io_byp_ack_i;
  assign ack_raw[1] = all_byp_ack_i;
  assign ack_raw[2] = stepdn_ack_i;

  generate
    for (genvar i = 0; i < NACK; i++) begin : g_ack_sync
      clkbyp_sync #(.W(MW), .STAGES(SYNC_STAGES), .RST_VAL(MUBI_OFF)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (ack_raw[i]),
        .q_o   (ack_syn[i])
      );
    end
  endgenerate

  mubi_t io_req_q, all_req_q, status_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      io_req_q  <= MUBI_OFF;
      all_req_q <= MUBI_OFF;
      status_q  <= MUBI_OFF;
    end else begin
      io_req_q  <= mubi_on(lc_byp_req_i) ? MUBI_ON : MUBI_OFF;
      all_req_q <= (mubi_on(sw_byp_req_i) && mubi_on(lc_dbg_en_i)) ? MUBI_ON : MUBI_OFF;
      status_q  <= ack_syn[1];
    end
  end

  clkbyp_lc_ack u_lc_ack (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .lc_req_i     (lc_byp_req_i),
    .io_ack_s_i   (ack_syn[0]),
    .step_ack_s_i (ack_syn[2]),
    .lc_ack_o     (lc_byp_ack_o)
  );

  clkbyp_div_ctl u_div (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .req_i  (stepdn_req_i),
    .step_o (div_step_o)
  );

  assign io_byp_req_o  = io_req_q;
  assign all_byp_req_o = all_req_q;
  assign ext_status_o  = status_q;
endmodule

// File: rtl/clkbyp_ctrl_chk.sv
module clkbyp_ctrl_chk
  import clkbyp_pkg::*;
(
  input logic          clk_i,
  input logic          rst_i,
  input logic [MW-1:0] lc_byp_req_i,
  input logic [MW-1:0] lc_dbg_en_i,
  input logic [MW-1:0] sw_byp_req_i,
  input logic [MW-1:0] stepdn_req_i,
  input logic [MW-1:0] io_byp_req_o,
  input logic [MW-1:0] all_byp_req_o,
  input logic [MW-1:0] lc_byp_ack_o,
  input logic [MW-1:0] div_step_o
);
  assert_io_req_src_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (io_byp_req_o == MUBI_ON) |-> $past(lc_byp_req_i == MUBI_ON));

  assert_all_req_gate_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (all_byp_req_o == MUBI_ON) |-> $past(sw_byp_req_i == MUBI_ON && lc_dbg_en_i == MUBI_ON));

  assert_lc_ack_drop_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (lc_byp_ack_o == MUBI_ON) |-> $past(lc_byp_req_i == MUBI_ON));

  assert_div_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (stepdn_req_i != MUBI_ON && stepdn_req_i != MUBI_OFF) |=> $stable(div_step_o));

  assert_out_legal_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (io_byp_req_o == MUBI_ON || io_byp_req_o == MUBI_OFF) &&
    (all_byp_req_o == MUBI_ON || all_byp_req_o == MUBI_OFF) &&
    (lc_byp_ack_o == MUBI_ON || lc_byp_ack_o == MUBI_OFF) &&
    (div_step_o == MUBI_ON || div_step_o == MUBI_OFF));
endmodule

bind clkbyp_ctrl clkbyp_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .lc_byp_req_i  (lc_byp_req_i),
  .lc_dbg_en_i   (lc_dbg_en_i),
  .sw_byp_req_i  (sw_byp_req_i),
  .stepdn_req_i  (stepdn_req_i),
  .io_byp_req_o  (io_byp_req_o),
  .all_byp_req_o (all_byp_req_o),
  .lc_byp_ack_o  (lc_byp_ack_o),
  .div_step_o    (div_step_o)
);

// File: tb/tb_clkbyp_ctrl.sv
`timescale 1ns/1ps
module tb_clkbyp_ctrl;
  localparam logic [3:0] ON  = 4'hA;
  localparam logic [3:0] OFF = 4'h5;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] lc_req, dbg, sw_req, io_ack, all_ack, sd_req, sd_ack;
  logic [3:0] io_req_o, all_req_o, lc_ack_o, div_o, stat_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clkbyp_ctrl dut (
    .clk_i         (clk),
    .rst_i         (rst),
    .lc_byp_req_i  (lc_req),
    .lc_dbg_en_i   (dbg),
    .sw_byp_req_i  (sw_req),
    .io_byp_ack_i  (io_ack),
    .all_byp_ack_i (all_ack),
    .stepdn_req_i  (sd_req),
    .stepdn_ack_i  (sd_ack),
    .io_byp_req_o  (io_req_o),
    .all_byp_req_o (all_req_o),
    .lc_byp_ack_o  (lc_ack_o),
    .div_step_o    (div_o),
    .ext_status_o  (stat_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    lc_req = OFF; dbg = OFF; sw_req = OFF; io_ack = OFF;
    all_ack = OFF; sd_req = OFF; sd_ack = OFF;
    step(3);
    chk("R1 io_req in reset", io_req_o, OFF);
    chk("R1 all_req in reset", all_req_o, OFF);
    chk("R1 lc_ack in reset", lc_ack_o, OFF);
    chk("R1 div in reset", div_o, OFF);
    chk("R1 status in reset", stat_o, OFF);
    rst = 1'b0;
    step(1);
    chk("R1 io_req after release", io_req_o, OFF);
    chk("R1 lc_ack after release", lc_ack_o, OFF);
  endtask

  task automatic t_io_req();
    for (int v = 0; v < 16; v++) begin
      lc_req = 4'(v);
      step(1);
      chk("R2 io_req decode", io_req_o, (4'(v) == ON) ? ON : OFF);
    end
    lc_req = OFF;
    step(1);
  endtask

  task automatic t_all_req();
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        sw_req = 4'(a);
        dbg = 4'(b);
        step(1);
        chk("R3 all_req gate", all_req_o, (4'(a) == ON && 4'(b) == ON) ? ON : OFF);
      end
    end
    sw_req = OFF; dbg = OFF;
    step(1);
  endtask

  task automatic t_status();
    for (int v = 0; v < 16; v++) begin
      all_ack = 4'(v);
      step(3);
      chk("R4 status copy", stat_o, 4'(v));
    end
    all_ack = OFF;
    step(3);
  endtask

  task automatic t_lc_ack();
    lc_req = ON;
    sd_ack = ON;
    step(4);
    chk("R5 lc_ack waits io ack", lc_ack_o, OFF);
    io_ack = ON;
    step(2);
    chk("R5 lc_ack not yet", lc_ack_o, OFF);
    step(1);
    chk("R5 lc_ack granted", lc_ack_o, ON);
    chk("R2 io_req while granted", io_req_o, ON);
  endtask

  task automatic t_invalid_ack();
    for (int v = 0; v < 16; v++) begin
      sd_ack = 4'(v);
      step(3);
      chk("R6 step ack strict", lc_ack_o, (4'(v) == ON) ? ON : OFF);
    end
    sd_ack = ON;
    for (int v = 0; v < 16; v++) begin
      io_ack = 4'(v);
      step(3);
      chk("R6 io ack strict", lc_ack_o, (4'(v) == ON) ? ON : OFF);
    end
    io_ack = ON;
    step(3);
  endtask

  task automatic t_drop();
    chk("R8 precondition ack on", lc_ack_o, ON);
    lc_req = 4'h0;
    step(1);
    chk("R8 io_req drops", io_req_o, OFF);
    chk("R8 lc_ack drops", lc_ack_o, OFF);
    io_ack = OFF; sd_ack = OFF; lc_req = OFF;
    step(4);
    chk("R8 lc_ack stays off", lc_ack_o, OFF);
  endtask

  task automatic t_div();
    sd_req = ON;
    step(1);
    chk("R7 div on", div_o, ON);
    for (int v = 0; v < 16; v++) begin
      if (4'(v) != ON && 4'(v) != OFF) begin
        sd_req = 4'(v);
        step(1);
        chk("R7 div holds on", div_o, ON);
      end
    end
    sd_req = OFF;
    step(1);
    chk("R7 div off", div_o, OFF);
    sd_req = 4'hF;
    step(1);
    chk("R7 div holds off", div_o, OFF);
    sd_req = 4'h0;
    step(1);
    chk("R9 div legal", div_o, OFF);
  endtask

  initial begin
    t_reset();
    t_io_req();
    t_all_req();
    t_status();
    t_lc_ack();
    t_invalid_ack();
    t_drop();
    t_div();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule